// File: doc/BRIEF.md
# Banked Nibble Working-Register File

This block stores the 4-bit working registers of a small processor core. It holds four banks of eight nibble registers, 32 nibbles in total. A bank-enable flag and a 2-bit bank select pick the active bank. Inside that bank a 3-bit register code names one of the eight registers. The datapath can read or write one bit of a register, a whole nibble, or a pair of registers taken together as a byte.

The same 32 nibbles also appear as plain data memory at addresses 00h to 1Fh. A raw access and a named access reach the same storage. Bank `b`, register offset `r` sits at address `b*8 + r`. Reads are combinational from the current control inputs. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `wreg_bank_file`

## Requirements
- R1: After reset every one of the 32 nibbles reads as 0.
- R2: A named register resolves to raw address `bank*8 + offset`. The offsets are A=0, E=1, L=2, H=3, X=4, W=5, Z=6, Y=7, and the bank is `bank_sel` when `bank_en` is 1.
- R3: When `bank_en` is 0, named accesses go to bank 0 whatever the value of `bank_sel`.
- R4: Nibble access (`acc_width`=1) reads `{4'h0, nibble}` and writes `wr_data[3:0]` into the named register.
- R5: Bit access (`acc_width`=0) reads the bit at `bit_idx` on `rd_data[0]`, with all other bits 0. A bit write stores `wr_data[0]` into that bit and leaves the other three bits unchanged.
- R6: Pair access (`acc_width`=2) uses pair codes 0=EA, 1=HL, 2=WX, 3=YZ, 4=WL. It reads `{high, low}`, where the low nibble is A, L, X, Z or L (for WL) respectively. A pair write updates both nibbles on the same clock edge.
- R7: Raw access (`acc_width`=3) reads and writes the nibble at `raw_addr` (0 to 31), ignoring `bank_en`, `bank_sel` and `reg_code`. It is the same storage as the named registers.
- R8: Pair codes 5, 6 and 7 raise `illegal`, read as 0 and write nothing. `illegal` is 0 for every other access.
- R9: Storage changes only on a rising clock edge with `wr_en` high. With `wr_en` low, the contents stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_en | input | 1 | Bank-enable flag; 0 forces bank 0 |
| bank_sel | input | 2 | Bank select |
| acc_width | input | 2 | 0 bit, 1 nibble, 2 pair, 3 raw address |
| reg_code | input | 3 | Register offset, or pair code in pair mode |
| bit_idx | input | 2 | Bit position for bit access |
| raw_addr | input | 5 | Raw data-memory address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Read data of the selected width |
| illegal | output | 1 | Unsupported pair code |

## Verification
Read data and `illegal` are combinational, so they are due in the same cycle as the control inputs. A write becomes visible to reads right after the rising edge that samples `wr_en`. The bench drives inputs on the falling edge and samples one nanosecond later, well clear of any rising edge. Each write is therefore checked after exactly one rising edge, and every read after its inputs have settled.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
  typedef enum logic [1:0] {
    ACC_BIT  = 2'd0,
    ACC_NIB  = 2'd1,
    ACC_PAIR = 2'd2,
    ACC_RAW  = 2'd3
  } acc_t;

  localparam logic [2:0] OFS_A = 3'd0;
  localparam logic [2:0] OFS_E = 3'd1;
  localparam logic [2:0] OFS_L = 3'd2;
  localparam logic [2:0] OFS_H = 3'd3;
  localparam logic [2:0] OFS_X = 3'd4;
  localparam logic [2:0] OFS_W = 3'd5;
  localparam logic [2:0] OFS_Z = 3'd6;
  localparam logic [2:0] OFS_Y = 3'd7;

  // pair code -> offset of low nibble
  function automatic logic [2:0] pair_low(input logic [2:0] pc);
    case (pc)
      3'd0:    pair_low = OFS_A;
      3'd1:    pair_low = OFS_L;
      3'd2:    pair_low = OFS_X;
      3'd3:    pair_low = OFS_Z;
      3'd4:    pair_low = OFS_L;
      default: pair_low = OFS_A;
    endcase
  endfunction

  // pair code -> offset of high nibble
  function automatic logic [2:0] pair_high(input logic [2:0] pc);
    case (pc)
      3'd0:    pair_high = OFS_E;
      3'd1:    pair_high = OFS_H;
      3'd2:    pair_high = OFS_W;
      3'd3:    pair_high = OFS_Y;
      3'd4:    pair_high = OFS_W;
      default: pair_high = OFS_E;
    endcase
  endfunction

  function automatic logic pair_legal(input logic [2:0] pc);
    pair_legal = (pc <= 3'd4);
  endfunction
endpackage

// File: rtl/wrf_decode.sv
`timescale 1ns/1ps
module wrf_decode
  import wrf_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int NIB_W = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int OFF_W = $clog2(REGS_PER_BANK),
  localparam int ADDR_W = BANK_W + OFF_W,
  localparam int BIT_W = $clog2(NIB_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_en,
  input  logic [BANK_W-1:0] bank_sel,
  input  acc_t              acc,
  input  logic [OFF_W-1:0]  reg_code,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [2*NIB_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic [NIB_W-1:0]  rd_lo,
  output logic [ADDR_W-1:0] lo_addr,
  output logic [ADDR_W-1:0] hi_addr,
  output logic              lo_we,
  output logic              hi_we,
  output logic [NIB_W-1:0]  lo_wdata,
  output logic [NIB_W-1:0]  hi_wdata,
  output logic              illegal
);
  logic [BANK_W-1:0] eff_bank;
  logic [OFF_W-1:0]  lo_off, hi_off;
  logic              pair_ok;

  assign eff_bank = bank_en ? bank_sel : '0;
  assign pair_ok  = pair_legal(3'(reg_code));

  always_comb begin
    lo_off = reg_code;
    hi_off = reg_code;
    if (acc == ACC_PAIR) begin
      lo_off = OFF_W'(pair_low(3'(reg_code)));
      hi_off = OFF_W'(pair_high(3'(reg_code)));
    end
  end

  always_comb begin
    if (acc == ACC_RAW) begin
      lo_addr = raw_addr;
      hi_addr = raw_addr;
    end else begin
      lo_addr = {eff_bank, lo_off};
      hi_addr = {eff_bank, hi_off};
    end
  end

  assign illegal = (acc == ACC_PAIR) && !pair_ok;

  always_comb begin
    lo_we    = wr_en && !illegal;
    hi_we    = wr_en && (acc == ACC_PAIR) && pair_ok;
    lo_wdata = wr_data[NIB_W-1:0];
    hi_wdata = wr_data[2*NIB_W-1:NIB_W];
    if (acc == ACC_BIT) begin
      lo_wdata = rd_lo;
      lo_wdata[bit_idx] = wr_data[0];
    end
  end

  // R8: an unsupported pair code never writes
  p_illegal_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!lo_we && !hi_we));

  // R3: flag low pins named accesses to bank 0
  p_bank_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_en && acc != ACC_RAW) |-> (lo_addr[ADDR_W-1:OFF_W] == '0 && hi_addr[ADDR_W-1:OFF_W] == '0));

  // R5: a bit write alters at most one bit of the nibble
  p_bit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_BIT && lo_we) |-> ($countones(lo_wdata ^ rd_lo) <= 1));

  // R6: a legal pair write drives two distinct nibbles together
  p_pair_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == ACC_PAIR && wr_en && !illegal) |-> (lo_we && hi_we && lo_addr != hi_addr));
endmodule

// File: rtl/wrf_store.sv
`timescale 1ns/1ps
module wrf_store #(
  parameter int DEPTH = 32,
  parameter int NIB_W = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lo_addr,
  input  logic [ADDR_W-1:0] hi_addr,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [NIB_W-1:0]  lo_wdata,
  input  logic [NIB_W-1:0]  hi_wdata,
  output logic [NIB_W-1:0]  rd_lo,
  output logic [NIB_W-1:0]  rd_hi
);
  logic [DEPTH-1:0][NIB_W-1:0] mem_q;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic             hit_lo, hit_hi, ent_en;
    logic [NIB_W-1:0] ent_d;

    always_comb begin
      hit_lo = lo_we && (lo_addr == ADDR_W'(gi));
      hit_hi = hi_we && (hi_addr == ADDR_W'(gi));
      ent_en = hit_lo || hit_hi;
      ent_d  = hit_hi ? hi_wdata : lo_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[gi] <= '0;
      else if (ent_en) mem_q[gi] <= ent_d;
    end
  end

  assign rd_lo = mem_q[lo_addr];
  assign rd_hi = mem_q[hi_addr];

  // R9: with no write strobe the contents hold
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_we && !hi_we) |=> $stable(mem_q));

  // R6: the high nibble of a pair write lands in storage
  p_hi_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> (mem_q[$past(hi_addr)] == $past(hi_wdata)));

  // R4: a low-side write lands unless the high side shares its address
  p_lo_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !(hi_we && hi_addr == lo_addr)) |=> (mem_q[$past(lo_addr)] == $past(lo_wdata)));
endmodule

// File: rtl/wreg_bank_file.sv
`timescale 1ns/1ps
module wreg_bank_file
  import wrf_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int NIB_W = 4,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int OFF_W = $clog2(REGS_PER_BANK),
  localparam int ADDR_W = BANK_W + OFF_W,
  localparam int BIT_W = $clog2(NIB_W),
  localparam int DEPTH = NUM_BANKS * REGS_PER_BANK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_en,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic [1:0]         acc_width,
  input  logic [OFF_W-1:0]   reg_code,
  input  logic [BIT_W-1:0]   bit_idx,
  input  logic [ADDR_W-1:0]  raw_addr,
  input  logic [2*NIB_W-1:0] wr_data,
  input  logic               wr_en,
  output logic [2*NIB_W-1:0] rd_data,
  output logic               illegal
);
  logic              rst_meta_n, rst_sync_n;
  acc_t              acc;
  logic [ADDR_W-1:0] lo_addr, hi_addr;
  logic              lo_we, hi_we;
  logic [NIB_W-1:0]  lo_wdata, hi_wdata, rd_lo, rd_hi;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign acc = acc_t'(acc_width);

  wrf_decode #(
    .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .NIB_W(NIB_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_sync_n),
    .bank_en(bank_en), .bank_sel(bank_sel), .acc(acc),
    .reg_code(reg_code), .bit_idx(bit_idx), .raw_addr(raw_addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_lo(rd_lo),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .lo_we(lo_we), .hi_we(hi_we),
    .lo_wdata(lo_wdata), .hi_wdata(hi_wdata), .illegal(illegal)
  );

  wrf_store #(.DEPTH(DEPTH), .NIB_W(NIB_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .lo_we(lo_we), .hi_we(hi_we),
    .lo_wdata(lo_wdata), .hi_wdata(hi_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi)
  );

  always_comb begin
    rd_data = '0;
    case (acc)
      ACC_BIT:  rd_data[0] = rd_lo[bit_idx];
      ACC_NIB:  rd_data[NIB_W-1:0] = rd_lo;
      ACC_PAIR: if (!illegal) rd_data = {rd_hi, rd_lo};
      default:  rd_data[NIB_W-1:0] = rd_lo;
    endcase
  end

  // R5: bit reads never set the upper seven bits
  p_bit_read_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc == ACC_BIT) |-> (rd_data[2*NIB_W-1:1] == '0));

  // R8: illegal pair reads return zero
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (rd_data == '0));
endmodule

// File: tb/wreg_bank_file_test.sv
`timescale 1ns/1ps
module wreg_bank_file_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bank_en;
  logic [1:0] bank_sel, acc_width, bit_idx;
  logic [2:0] reg_code;
  logic [4:0] raw_addr;
  logic [7:0] wr_data;
  logic       wr_en;
  logic [7:0] rd_data;
  logic       illegal;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [32];

  always #4 clk = ~clk;  // 125 MHz

  wreg_bank_file uut (
    .clk(clk), .rst_n(rst_n), .bank_en(bank_en), .bank_sel(bank_sel),
    .acc_width(acc_width), .reg_code(reg_code), .bit_idx(bit_idx),
    .raw_addr(raw_addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_data(rd_data), .illegal(illegal)
  );

  function automatic int lo_of(input int pc);
    case (pc) 0: return 0; 1: return 2; 2: return 4; 3: return 6; default: return 2; endcase
  endfunction
  function automatic int hi_of(input int pc);
    case (pc) 0: return 1; 1: return 3; 2: return 5; 3: return 7; default: return 5; endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic setin(input int acc, input bit en, input int sel, input int code,
                       input int bi, input int addr, input logic [7:0] d, input bit we);
    acc_width = 2'(acc); bank_en = en; bank_sel = 2'(sel); reg_code = 3'(code);
    bit_idx = 2'(bi); raw_addr = 5'(addr); wr_data = d; wr_en = we;
  endtask

  task automatic wr(input int acc, input bit en, input int sel, input int code,
                    input int bi, input int addr, input logic [7:0] d);
    @(negedge clk);
    setin(acc, en, sel, code, bi, addr, d, 1'b1);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input int acc, input bit en, input int sel, input int code,
                    input int bi, input int addr, output logic [7:0] q);
    @(negedge clk);
    setin(acc, en, sel, code, bi, addr, 8'h00, 1'b0);
    #1 q = rd_data;
  endtask

  task automatic raw_all(input string req);
    logic [7:0] q;
    for (int a = 0; a < 32; a++) begin
      rd(3, 1'b0, 0, 0, 0, a, q);
      check(req, q, {4'h0, model[a]});
    end
  endtask

  task automatic t_reset;  // R1
    raw_all("R1 reset value");
  endtask

  task automatic t_named_nibbles;  // R2, R4
    logic [7:0] q;
    for (int b = 0; b < 4; b++)
      for (int r = 0; r < 8; r++) begin
        logic [3:0] v;
        v = 4'(b * 8 + r + 3);
        wr(1, 1'b1, b, r, 0, 0, {4'hF, v});
        model[b*8+r] = v;
      end
    raw_all("R2 named to raw address");
    rd(1, 1'b1, 2, 5, 0, 0, q);
    check("R4 nibble read bank2 W", q, {4'h0, model[21]});
  endtask

  task automatic t_bank_disable;  // R3
    logic [7:0] q;
    wr(1, 1'b0, 3, 5, 0, 0, 8'h0A);
    model[5] = 4'hA;
    rd(3, 1'b0, 0, 0, 0, 5, q);
    check("R3 flag low writes bank0", q, 8'h0A);
    rd(3, 1'b0, 0, 0, 0, 29, q);
    check("R3 bank3 untouched", q, {4'h0, model[29]});
    rd(1, 1'b0, 2, 5, 0, 0, q);
    check("R3 flag low reads bank0", q, 8'h0A);
  endtask

  task automatic t_bits;  // R5
    logic [7:0] q;
    wr(1, 1'b1, 1, 4, 0, 0, 8'h05);
    model[12] = 4'h5;
    wr(0, 1'b1, 1, 4, 1, 0, 8'hFF);
    model[12] = 4'h7;
    rd(1, 1'b1, 1, 4, 0, 0, q);
    check("R5 bit1 set others kept", q, 8'h07);
    wr(0, 1'b1, 1, 4, 0, 0, 8'hFE);
    model[12] = 4'h6;
    rd(1, 1'b1, 1, 4, 0, 0, q);
    check("R5 bit0 cleared others kept", q, 8'h06);
    for (int i = 0; i < 4; i++) begin
      rd(0, 1'b1, 1, 4, i, 0, q);
      check("R5 bit read", q, {7'h0, model[12][i]});
    end
  endtask

  task automatic t_pairs;  // R6
    logic [7:0] q;
    for (int pc = 0; pc < 5; pc++) begin
      logic [7:0] v;
      v = 8'(8'hC5 + pc * 8'h13);
      wr(2, 1'b1, 2, pc, 0, 0, v);
      model[16 + lo_of(pc)] = v[3:0];
      model[16 + hi_of(pc)] = v[7:4];
      rd(2, 1'b1, 2, pc, 0, 0, q);
      check("R6 pair readback", q, v);
      rd(1, 1'b1, 2, lo_of(pc), 0, 0, q);
      check("R6 low nibble register", q, {4'h0, v[3:0]});
      rd(1, 1'b1, 2, hi_of(pc), 0, 0, q);
      check("R6 high nibble register", q, {4'h0, v[7:4]});
    end
    raw_all("R6 pair writes touch only their nibbles");
  endtask

  task automatic t_raw;  // R7
    logic [7:0] q;
    wr(3, 1'b1, 0, 2, 0, 31, 8'hF6);
    model[31] = 4'h6;
    rd(1, 1'b1, 3, 7, 0, 0, q);
    check("R7 raw write seen as bank3 Y", q, 8'h06);
    rd(3, 1'b1, 1, 3, 0, 9, q);
    check("R7 raw read ignores bank inputs", q, {4'h0, model[9]});
  endtask

  task automatic t_illegal;  // R8
    logic [7:0] q;
    for (int pc = 5; pc < 8; pc++) begin
      @(negedge clk);
      setin(2, 1'b1, 0, pc, 0, 0, 8'hFF, 1'b1);
      #1;
      check("R8 illegal flag", {7'h0, illegal}, 8'h01);
      check("R8 illegal read zero", rd_data, 8'h00);
      @(posedge clk);
      #1 wr_en = 1'b0;
    end
    rd(2, 1'b1, 0, 1, 0, 0, q);
    check("R8 legal pair flag low", {7'h0, illegal}, 8'h00);
    raw_all("R8 illegal pair wrote nothing");
  endtask

  task automatic t_no_strobe;  // R9
    @(negedge clk);
    setin(1, 1'b1, 0, 0, 0, 0, 8'h0E, 1'b0);
    repeat (2) @(posedge clk);
    raw_all("R9 no write without strobe");
  endtask

  initial begin
    for (int a = 0; a < 32; a++) model[a] = 4'h0;
    rst_n = 1'b0;
    setin(1, 1'b0, 0, 0, 0, 0, 8'h00, 1'b0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_named_nibbles();
    t_bank_disable();
    t_bits();
    t_pairs();
    t_raw();
    t_illegal();
    t_no_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule